// File: doc/BRIEF.md
# E3 Receive Alarm Interrupt Block

This block sits behind an E3 receive framer and turns the framer's error pulses into host interrupts. Three single-cycle event inputs arrive from the framer: a frame alignment word mismatch, a BIP-4 parity error and a far-end receive failure indication. Each event has an enable bit. An event whose enable bit is set latches a status bit, and the status bits drive an active-high interrupt request. Status bits are cleared by reading them.

Each BIP-4 parity error also adds one to a 16-bit saturating event counter, whether or not its interrupt is enabled. The host reads the counter as two bytes. Reading the upper byte captures the lower byte into a holding register and zeroes the counter, so the two reads return one coherent count taken over a single interval. The host uses a byte-wide port: an address, read and write strobes, and combinational read data that is valid while the read strobe is high.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: After reset the enable register, the status register and the counter all read 0x00, and the interrupt request is low.
- R2: The enable register is at address 0x13. Bit 3 enables far-end receive failure, bit 2 enables BIP-4 error and bit 1 enables framing error. A write sets or clears those three bits, and bits 7..4 and bit 0 always read 0.
- R3: When an event pulse arrives with its enable bit set, the matching status bit at address 0x15 (same bit positions as in R2) reads 1 from the next cycle, and the interrupt request goes high.
- R4: An event pulse whose enable bit is clear leaves its status bit at 0 and leaves the interrupt request low.
- R5: A read of address 0x15 returns the current status and clears the bits it returned. The interrupt request is low once no enabled status bit remains.
- R6: If an enabled event arrives in the same cycle as a status read, that read returns the earlier value and the event's status bit stays set afterwards.
- R7: Every BIP-4 pulse adds one to the counter. Address 0x54 returns the counter's upper byte. Address 0x55 returns the lower byte as it was captured by the last read of 0x54.
- R8: A read of 0x54 clears the counter. A BIP-4 pulse in that same cycle is counted as the first event of the new interval.
- R9: The counter stops at 0xFFFF and does not wrap.
- R10: Writes to the status register, to the counter addresses and to unused bit positions have no effect.
- R11: A read of any address other than 0x13, 0x15, 0x54 or 0x55 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fas_err_i | input | 1 | Framing word mismatch pulse |
| bip_err_i | input | 1 | BIP-4 parity error pulse |
| ferf_i | input | 1 | Far-end receive failure pulse |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; read side effects take place at the clock edge |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The status path is driven with events while their enables are clear, with single enabled events, and with two enabled events in the same cycle. These cases show whether the enable gating, the bit positions and the clear-on-read each work. A status read that coincides with a new event shows whether the clear takes priority over the set. The counter is tested with short bursts, a count larger than 255 (so that a mix-up between the upper and lower byte shows), a BIP-4 pulse in the same cycle as the clearing read, and a long continuous run that reaches the saturation limit.

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq #(
  parameter logic [7:0] A_ENA = 8'h13,
  parameter logic [7:0] A_STS = 8'h15,
  parameter logic [7:0] A_CHI = 8'h54,
  parameter logic [7:0] A_CLO = 8'h55,
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fas_err_i,
  input  logic       bip_err_i,
  input  logic       ferf_i,
  input  logic [7:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       ena_q, sts_q, evt, sts_clr;
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic [7:0]       lo_hold_q, rmux;
  logic             sts_rd, chi_rd;

  assign evt     = {ferf_i, bip_err_i, fas_err_i};
  assign sts_rd  = rd_i && (addr_i == A_STS);
  assign chi_rd  = rd_i && (addr_i == A_CHI);
  assign sts_clr = sts_rd ? sts_q : 3'b000;
  assign cnt_base = chi_rd ? '0 : cnt_q;
  assign irq_o   = |(sts_q & ena_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q     <= '0;
      sts_q     <= '0;
      cnt_q     <= '0;
      lo_hold_q <= '0;
    end else begin
      if (wr_i && addr_i == A_ENA) ena_q <= wdata_i[3:1];
      sts_q <= (sts_q & ~sts_clr) | (evt & ena_q);
      if (bip_err_i && cnt_base != CNT_MAX) cnt_q <= cnt_base + 1'b1;
      else cnt_q <= cnt_base;
      if (chi_rd) lo_hold_q <= cnt_q[7:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_ENA:   rmux = {4'b0, ena_q, 1'b0};
      A_STS:   rmux = {4'b0, sts_q, 1'b0};
      A_CHI:   rmux = cnt_q[15:8];
      A_CLO:   rmux = lo_hold_q;
      default: rmux = 8'h00;
    endcase
  end

  assign rdata_o = rd_i ? rmux : 8'h00;
endmodule

module e3_rx_alarm_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  evt,
  input logic [2:0]  ena,
  input logic [2:0]  sts,
  input logic [15:0] cnt,
  input logic        sts_rd,
  input logic        chi_rd,
  input logic        rd,
  input logic [7:0]  addr,
  input logic [7:0]  rdata,
  input logic        irq
);
  // R3
  set_on_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ena) != 3'b000) |=> ((sts & $past(evt & ena)) == $past(evt & ena)));
  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(evt & ena)) == 3'b000));
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && (evt & ena) == 3'b000) |=> (sts == 3'b000));
  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == 3'b000) |-> !irq);
  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chi_rd && cnt == 16'hFFFF) |=> (cnt == 16'hFFFF));
  // R2
  ena_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == 8'h13 || addr == 8'h15)) |-> (rdata[7:4] == 4'h0 && !rdata[0]));
endmodule

bind e3_rx_alarm_irq e3_rx_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .ena(ena_q), .sts(sts_q), .cnt(cnt_q),
  .sts_rd(sts_rd), .chi_rd(chi_rd), .rd(rd_i), .addr(addr_i),
  .rdata(rdata_o), .irq(irq_o)
);

// File: tb/tb_e3_rx_alarm_irq.sv
module tb_e3_rx_alarm_irq;
  logic clk = 0, rst_n = 0;
  logic fas = 0, bip = 0, ferf = 0, wr = 0, rd = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic irq;
  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  e3_rx_alarm_irq dut (
    .clk(clk), .rst_n(rst_n), .fas_err_i(fas), .bip_err_i(bip), .ferf_i(ferf),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, addr, rdata, e);
      end
    end
  end

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t,
                        input logic [2:0] evs = 3'b000);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 addr = a; rd = 1; {ferf, bip, fas} = evs;
    @(posedge clk); #1 rd = 0; {ferf, bip, fas} = 3'b000;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic pulse(input logic [2:0] evs, input int n = 1);
    @(posedge clk); #1 {ferf, bip, fas} = evs;
    repeat (n) @(posedge clk);
    #1 {ferf, bip, fas} = 3'b000;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk_irq(0, "R1 reset irq");
    rd_exp(8'h13, 8'h00, "R1 enable after reset");
    rd_exp(8'h15, 8'h00, "R1 status after reset");
    rd_exp(8'h54, 8'h00, "R1 counter after reset");
    // R2
    wr_reg(8'h13, 8'hFF);
    rd_exp(8'h13, 8'h0E, "R2 enable all ones");
    wr_reg(8'h13, 8'h00);
    rd_exp(8'h13, 8'h00, "R2 enable cleared");
    // R4: events while disabled (one BIP counted)
    pulse(3'b111);
    chk_irq(0, "R4 disabled irq");
    rd_exp(8'h15, 8'h00, "R4 disabled status");
    // R3 / R5
    wr_reg(8'h13, 8'h02);
    pulse(3'b001);
    chk_irq(1, "R3 framing irq");
    rd_exp(8'h15, 8'h02, "R3 framing status");
    chk_irq(0, "R5 irq after read");
    rd_exp(8'h15, 8'h00, "R5 status cleared");
    wr_reg(8'h13, 8'h0E);
    pulse(3'b110);
    chk_irq(1, "R3 ferf+bip irq");
    rd_exp(8'h15, 8'h0C, "R3 ferf+bip status");
    // R6
    pulse(3'b001);
    rd_exp(8'h15, 8'h02, "R6 read during event", 3'b001);
    chk_irq(1, "R6 irq kept");
    rd_exp(8'h15, 8'h02, "R6 bit kept");
    rd_exp(8'h15, 8'h00, "R6 then cleared");
    // R10
    wr_reg(8'h15, 8'hFF);
    rd_exp(8'h15, 8'h00, "R10 status write ignored");
    chk_irq(0, "R10 irq after status write");
    wr_reg(8'h54, 8'hAA);
    wr_reg(8'h55, 8'h55);
    // R7: two BIP pulses so far
    rd_exp(8'h54, 8'h00, "R7 hi byte count 2");
    rd_exp(8'h55, 8'h02, "R7 lo byte count 2");
    pulse(3'b010, 300);
    rd_exp(8'h54, 8'h01, "R7 hi byte count 300");
    rd_exp(8'h55, 8'h2C, "R7 lo byte count 300");
    rd_exp(8'h15, 8'h04, "R3 bip status");
    // R8
    pulse(3'b010, 3);
    rd_exp(8'h54, 8'h00, "R8 hi byte with event", 3'b010);
    rd_exp(8'h55, 8'h03, "R8 latched lo 3");
    rd_exp(8'h54, 8'h00, "R8 hi after clear");
    rd_exp(8'h55, 8'h01, "R8 same-cycle event kept");
    // R11
    rd_exp(8'h20, 8'h00, "R11 unused address");
    rd_exp(8'h14, 8'h00, "R11 gap address");
    // R9
    pulse(3'b010, 65600);
    rd_exp(8'h54, 8'hFF, "R9 saturated hi");
    rd_exp(8'h55, 8'hFF, "R9 saturated lo");
    rd_exp(8'h54, 8'h00, "R9 cleared after read");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule